// File: doc/BRIEF.md
# Protected memory word controller

This block is a small data-memory wrapper that adds write protection to single words. A client issues one command per cycle on a request port qualified by a valid bit. The command can read a word, write a word, lock a word against writes, or release a locked word. Releasing a word also wipes its stored value to zero. A write aimed at a locked word is dropped, and the block raises a one-cycle exception pulse in its place. Reads are never refused.

The address input is 32 bits wide. The storage is a behavioural array of `DEPTH` 16-bit words, indexed by the low `log2(DEPTH)` address bits. The block keeps one lock bit for each word, and reset clears every lock bit and every stored word. Read data and the exception pulse are both registered, so each appears in the cycle after the request that caused it.

Top module: `pmem_ctrl`

## Requirements
- R1: During and right after reset, `rd_valid` and `exc_pulse` are low. Every lock bit is clear and every word reads back as zero.
- R2: An accepted read raises `rd_valid` in the following cycle, and `rd_data` then carries the stored word. When no read was accepted in the previous cycle, `rd_valid` is low.
- R3: An accepted write to an unlocked word stores `req_wdata` and raises no exception.
- R4: An accepted write to a locked word leaves the stored word unchanged. `exc_pulse` is high in the cycle after that write, and only for that one cycle per blocked write.
- R5: A protect command locks the addressed word and raises no exception. Protecting a word that is already locked keeps it locked.
- R6: A free command unlocks the addressed word and sets its content to zero, without raising an exception. A free applied to an unlocked word still zeroes it.
- R7: A lock never blocks a read. A read of a locked word returns its stored value.
- R8: The word index is `req_addr[log2(DEPTH)-1:0]`. Addresses that differ only in higher bits select the same word.
- R9: `req_cmd` encodes read as 2'b00, write as 2'b01, protect as 2'b10 and free as 2'b11. A request with `req_valid` low changes no word and no lock bit, and it raises neither output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request qualifier; one command per cycle |
| req_cmd | input | 2 | Command code (see R9) |
| req_addr | input | 32 | Word address; low bits index the array |
| req_wdata | input | 16 | Data for write commands |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 16 | Registered read data |
| exc_pulse | output | 1 | One-cycle pulse for a blocked write |

## Verification
The assertions assume that `req_cmd` and `req_addr` are stable, known values whenever `req_valid` is high, and that `req_valid` is low during reset. The cross-cycle properties that compare indices of consecutive requests also rely on this. The bench drives every input at the falling edge, holds `req_valid` low for the whole reset phase, and draws random commands only from the four legal codes. Random addresses keep the low index inside a small window so that lock, write and free commands keep colliding on the same words, and the random upper bits exercise index aliasing.

// File: rtl/pmem_pkg.sv
package pmem_pkg;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 16;

    typedef enum logic [1:0] {
        CMD_READ    = 2'b00,
        CMD_WRITE   = 2'b01,
        CMD_PROTECT = 2'b10,
        CMD_FREE    = 2'b11
    } cmd_e;

    typedef struct packed {
        logic              valid;
        cmd_e              cmd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } req_t;

    typedef struct packed {
        logic do_read;
        logic do_write;
        logic do_protect;
        logic do_free;
    } op_t;

    function automatic op_t decode_cmd(input logic valid, input cmd_e cmd);
        op_t o;
        o.do_read    = valid && (cmd == CMD_READ);
        o.do_write   = valid && (cmd == CMD_WRITE);
        o.do_protect = valid && (cmd == CMD_PROTECT);
        o.do_free    = valid && (cmd == CMD_FREE);
        return o;
    endfunction

endpackage

// File: rtl/pmem_decode.sv
module pmem_decode
    import pmem_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  req_t             req,
    output op_t              op,
    output logic [IDX_W-1:0] idx
);
    logic unused_hi;

    always_comb begin
        op  = decode_cmd(req.valid, req.cmd);
        idx = req.addr[IDX_W-1:0];
    end

    assign unused_hi = ^req.addr[ADDR_W-1:IDX_W];
endmodule

// File: rtl/pmem_guard.sv
module pmem_guard #(
    parameter int DEPTH = 256,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] idx,
    output logic             locked
);
    logic [DEPTH-1:0] lock_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_lock
        always_ff @(posedge clk) begin
            if (rst) begin
                lock_q[g] <= 1'b0;
            end else if (idx == IDX_W'(g)) begin
                if (clr_en)      lock_q[g] <= 1'b0;
                else if (set_en) lock_q[g] <= 1'b1;
            end
        end
    end

    assign locked = lock_q[idx];
endmodule

// File: rtl/pmem_store.sv
module pmem_store #(
    parameter int DEPTH  = 256,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic              wipe_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (wipe_en) begin
            mem_q[idx] <= '0;
        end else if (wr_en) begin
            mem_q[idx] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata_q <= '0;
        else if (rd_en) rdata_q <= mem_q[idx];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/pmem_ctrl.sv
module pmem_ctrl
    import pmem_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              exc_pulse
);
    req_t             req;
    op_t              op;
    logic [IDX_W-1:0] idx;
    logic             locked;
    logic             wr_ok;
    logic             wr_blocked;
    logic             rd_valid_q;
    logic             exc_q;

    always_comb begin
        req.valid = req_valid;
        req.cmd   = cmd_e'(req_cmd);
        req.addr  = req_addr;
        req.wdata = req_wdata;
    end

    pmem_decode #(.IDX_W(IDX_W)) u_decode (
        .req (req),
        .op  (op),
        .idx (idx)
    );

    pmem_guard #(.DEPTH(DEPTH)) u_guard (
        .clk    (clk),
        .rst    (rst),
        .set_en (op.do_protect),
        .clr_en (op.do_free),
        .idx    (idx),
        .locked (locked)
    );

    assign wr_ok      = op.do_write && !locked;
    assign wr_blocked = op.do_write && locked;

    pmem_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (op.do_read),
        .wr_en   (wr_ok),
        .wipe_en (op.do_free),
        .idx     (idx),
        .wdata   (req.wdata),
        .rdata   (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid_q <= 1'b0;
            exc_q      <= 1'b0;
        end else begin
            rd_valid_q <= op.do_read;
            exc_q      <= wr_blocked;
        end
    end

    assign rd_valid  = rd_valid_q;
    assign exc_pulse = exc_q;
endmodule

// File: rtl/pmem_ctrl_chk.sv
module pmem_ctrl_chk
    import pmem_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [1:0]        req_cmd,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic              exc_pulse
);
    logic             is_rd, is_wr, is_prot, is_free;
    logic [IDX_W-1:0] cidx;

    assign is_rd   = req_valid && (req_cmd == 2'b00);
    assign is_wr   = req_valid && (req_cmd == 2'b01);
    assign is_prot = req_valid && (req_cmd == 2'b10);
    assign is_free = req_valid && (req_cmd == 2'b11);
    assign cidx    = req_addr[IDX_W-1:0];

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!rd_valid && !exc_pulse)); // R1

    AST_RD_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        is_rd |=> rd_valid); // R2

    AST_RD_ONLY_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(is_rd)); // R2

    AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (rst)
        ($past(is_wr, 2) && $past(is_rd) && !$past(exc_pulse) &&
         ($past(cidx) == $past(cidx, 2))) |-> (rd_data == $past(req_wdata, 2))); // R3

    AST_EXC_CAUSE: assert property (@(posedge clk) disable iff (rst)
        exc_pulse |-> $past(is_wr)); // R4

    AST_PROTECT_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (is_wr && $past(is_prot) && (cidx == $past(cidx))) |=> exc_pulse); // R5

    AST_FREE_WIPES: assert property (@(posedge clk) disable iff (rst)
        ($past(is_free, 2) && $past(is_rd) &&
         ($past(cidx) == $past(cidx, 2))) |-> (rd_data == '0)); // R6

    AST_FREE_UNLOCKS: assert property (@(posedge clk) disable iff (rst)
        (is_wr && $past(is_free) && (cidx == $past(cidx))) |=> !exc_pulse); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rd_valid && !exc_pulse)); // R9
endmodule

bind pmem_ctrl pmem_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_cmd   (req_cmd),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .exc_pulse (exc_pulse)
);

// File: tb/pmem_ctrl_tb.sv
module pmem_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 256;
    localparam int IDX_W      = $clog2(DEPTH);
    localparam int N_RANDOM   = 3000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_cmd = 2'b00;
    logic [31:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic        exc_pulse;

    int n_tests = 0;
    int n_fail  = 0;
    logic [15:0] m_mem  [DEPTH];
    logic        m_lock [DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    pmem_ctrl #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .exc_pulse(exc_pulse)
    );

    function automatic int widx(input logic [31:0] a);
        return int'(a[IDX_W-1:0]);
    endfunction

    function automatic logic exp_exc(input logic v, input logic [1:0] c, input logic [31:0] a);
        return v && (c == 2'b01) && m_lock[widx(a)];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_apply(input logic v, input logic [1:0] c,
                               input logic [31:0] a, input logic [15:0] d);
        int i;
        i = widx(a);
        if (v) begin
            case (c)
                2'b01: if (!m_lock[i]) m_mem[i] = d;
                2'b10: m_lock[i] = 1'b1;
                2'b11: begin m_lock[i] = 1'b0; m_mem[i] = '0; end
                default: ;
            endcase
        end
    endtask

    // Drive at a falling edge, check outputs at the next falling edge.
    task automatic op(input string req, input logic v, input logic [1:0] c,
                      input logic [31:0] a, input logic [15:0] d);
        logic        e_rv, e_ex;
        logic [15:0] e_rd;
        e_rv = v && (c == 2'b00);
        e_rd = m_mem[widx(a)];
        e_ex = exp_exc(v, c, a);
        req_valid = v; req_cmd = c; req_addr = a; req_wdata = d;
        model_apply(v, c, a, d);
        @(negedge clk);
        check({req, " rd_valid"}, 32'(rd_valid), 32'(e_rv));
        check({req, " exc_pulse"}, 32'(exc_pulse), 32'(e_ex));
        if (e_rv) check({req, " rd_data"}, 32'(rd_data), 32'(e_rd));
        req_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] a;
        for (int i = 0; i < DEPTH; i++) begin m_mem[i] = '0; m_lock[i] = 1'b0; end
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        check("R1 rd_valid in reset", 32'(rd_valid), 0);
        check("R1 exc_pulse in reset", 32'(exc_pulse), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 rd_valid after reset", 32'(rd_valid), 0);
        // R1: words read zero, writes not blocked after reset
        op("R1 read zero", 1, 2'b00, 32'h0000_0005, '0);
        op("R1 unlocked write", 1, 2'b01, 32'h0000_0007, 16'h1111);
        // R2/R3: write then read back
        op("R3 write", 1, 2'b01, 32'h0000_0010, 16'hBEEF);
        op("R2 readback", 1, 2'b00, 32'h0000_0010, '0);
        // R5/R4: lock then blocked write
        op("R5 protect", 1, 2'b10, 32'h0000_0010, '0);
        op("R5 protect again", 1, 2'b10, 32'h0000_0010, '0);
        op("R4 blocked write", 1, 2'b01, 32'h0000_0010, 16'h0BAD);
        op("R4 second blocked write", 1, 2'b01, 32'h0000_0010, 16'h0BAD);
        // R7: reads of locked word allowed
        op("R7 read locked", 1, 2'b00, 32'h0000_0010, '0);
        op("R4 no exc after read", 1, 2'b00, 32'h0000_0011, '0);
        // R8: aliasing via high bits
        op("R8 blocked alias write", 1, 2'b01, 32'hABCD_0010, 16'h2222);
        op("R8 alias read", 1, 2'b00, 32'h7700_0010, '0);
        // R9: idle request with write command to unlocked word
        op("R9 idle write", 0, 2'b01, 32'h0000_0007, 16'hFFFF);
        op("R9 idle free", 0, 2'b11, 32'h0000_0010, '0);
        op("R9 state kept", 1, 2'b00, 32'h0000_0007, '0);
        op("R9 lock kept", 1, 2'b01, 32'h0000_0010, 16'h3333);
        // R6: free locked and unlocked words
        op("R6 free locked", 1, 2'b11, 32'h0000_0010, '0);
        op("R6 read after free", 1, 2'b00, 32'h0000_0010, '0);
        op("R6 write after free", 1, 2'b01, 32'h0000_0010, 16'h4444);
        op("R6 free unlocked", 1, 2'b11, 32'h0000_0007, '0);
        op("R6 read zeroed", 1, 2'b00, 32'h0000_0007, '0);
        // boundary index
        op("R8 top word write", 1, 2'b01, 32'hFFFF_FFFF, 16'h5A5A);
        op("R8 top word read", 1, 2'b00, 32'h0000_00FF, '0);
        // constrained random over a small index window
        for (int n = 0; n < N_RANDOM; n++) begin
            a = $urandom;
            a[IDX_W-1:0] = IDX_W'($urandom_range(0, 7));
            op("R2-random", ($urandom_range(0, 9) != 0), 2'($urandom_range(0, 3)),
               a, 16'($urandom));
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule